// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block joins two eight-bit data buses, A and B, through a non-inverting buffered path whose direction is set by a single direction input. With the direction input high the block transmits: A data is presented on B. With it low the block receives: B data is presented on A. An active-low output enable releases both data buses whenever it is high. Each bus, and the shared parity line, is modelled as separate data-out and drive-enable signals, so the surrounding pad logic decides how the line is resolved.

A parity line travels with the data. While transmitting, the block computes a parity bit over the A data and drives it onto the parity line. While receiving, the same line is an input. The block checks it together with the B data and pulls an active-low error flag when the combined count disagrees with the chosen parity sense. A select input chooses even (low) or odd (high) parity for both generation and checking. Every output is a purely combinational function of the present inputs.

Top module: `parity_xcvr`

## Requirements
- R1: With `dir_tx`=1 and `oe_n`=0, `b_out` equals `a_in` bit for bit, `b_oe`=1 and `a_oe`=0.
- R2: With `dir_tx`=0 and `oe_n`=0, `a_out` equals `b_in` bit for bit, `a_oe`=1 and `b_oe`=0.
- R3: With `oe_n`=1, `a_oe`=0 and `b_oe`=0 for either value of `dir_tx`.
- R4: With `dir_tx`=1 and `odd_sel`=0 (even parity), `par_out`=1 exactly when `a_in` holds an odd number of ones.
- R5: With `dir_tx`=1 and `odd_sel`=1 (odd parity), `par_out`=1 exactly when `a_in` holds an even number of ones.
- R6: With `dir_tx`=0, `oe_n`=0 and `odd_sel`=0, `err_n`=0 exactly when the ones in `b_in` plus `par_in` add up to an odd count; otherwise `err_n`=1.
- R7: With `dir_tx`=0, `oe_n`=0 and `odd_sel`=1, `err_n`=0 exactly when the ones in `b_in` plus `par_in` add up to an even count; otherwise `err_n`=1.
- R8: `par_oe`=1 only when `dir_tx`=1 and `oe_n`=0; in every other case `par_oe`=0.
- R9: `err_n`=1 whenever `dir_tx`=1 or `oe_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | Direction: 1 moves A to B and generates parity, 0 moves B to A and checks parity |
| oe_n | input | 1 | Active-low output enable for both buses and the parity line |
| odd_sel | input | 1 | Parity sense: 0 even, 1 odd |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value to drive on bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value to drive on bus B |
| b_oe | output | 1 | Drive enable for bus B |
| par_in | input | 1 | Value seen on the parity line |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity line |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The assertions are immediate checks on settled combinational values. They take for granted that every input carries a defined 0 or 1 and that all inputs of one pattern are applied together before the outputs are looked at, because a half-applied pattern could briefly look like a parity mismatch. The bench applies each pattern in a single step at the falling edge of its clock and samples half a period later. It walks all eight combinations of direction, enable and parity sense, using all-zero, all-one, single-bit and random bus values with both parity-line levels.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

   // how an XOR reduction is built
   typedef enum logic {
      XOR_FLAT = 1'b0,
      XOR_TREE = 1'b1
   } xor_style_e;

   // drive and check enables derived from the mode inputs
   typedef struct packed {
      logic a_drv;
      logic b_drv;
      logic p_drv;
      logic chk_on;
   } xcvr_ctl_t;

endpackage

// File: rtl/xor_reduce.sv
module xor_reduce
   import parity_xcvr_pkg::*;
#(
   parameter int         W     = 8,
   parameter xor_style_e STYLE = XOR_TREE
) (
   input  logic [W-1:0] din,
   output logic         odd
);
   localparam int LEVELS = (W > 1) ? $clog2(W) : 1;
   localparam int LEAVES = 1 << LEVELS;
   localparam int NODES  = 2 * LEAVES - 1;

   generate
      if (W < 1) begin : g_bad_width
         $error("xor_reduce: W must be at least 1");
      end

      if (STYLE == XOR_FLAT) begin : g_flat
         assign odd = ^din;
      end else begin : g_tree
         logic [NODES-1:0] node;
         // leaves occupy the upper half of the heap, padded with zeros
         for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < W) begin : g_used
               assign node[LEAVES-1+i] = din[i];
            end else begin : g_pad
               assign node[LEAVES-1+i] = 1'b0;
            end
         end
         for (genvar n = 0; n < LEAVES - 1; n++) begin : g_inner
            assign node[n] = node[2*n+1] ^ node[2*n+2];
         end
         assign odd = node[0];
      end
   endgenerate
endmodule

// File: rtl/xcvr_mode.sv
module xcvr_mode
   import parity_xcvr_pkg::*;
(
   input  logic      dir_tx,
   input  logic      oe_n,
   output xcvr_ctl_t ctl
);
   logic live;

   always_comb begin
      live       = ~oe_n;
      ctl.a_drv  = live & ~dir_tx;
      ctl.b_drv  = live &  dir_tx;
      ctl.p_drv  = live &  dir_tx;
      ctl.chk_on = live & ~dir_tx;
   end
endmodule

// File: rtl/parity_check.sv
module parity_check (
   input  logic chk_on,
   input  logic odd_sel,
   input  logic rx_odd,
   output logic err_n
);
   logic mismatch;

   // received group (data plus parity bit) must have odd count for odd sense
   always_comb begin
      mismatch = rx_odd ^ odd_sel;
      err_n    = ~(chk_on & mismatch);
   end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
   import parity_xcvr_pkg::*;
#(
   parameter int         W     = 8,
   parameter xor_style_e STYLE = XOR_TREE
) (
   input  logic         dir_tx,
   input  logic         oe_n,
   input  logic         odd_sel,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   input  logic         par_in,
   output logic         par_out,
   output logic         par_oe,
   output logic         err_n
);
   localparam int RXW = W + 1;

   generate
      if (W < 1) begin : g_bad_width
         $error("parity_xcvr: W must be at least 1");
      end
   endgenerate

   xcvr_ctl_t ctl;
   logic      tx_odd;
   logic      rx_odd;

   xcvr_mode u_mode (
      .dir_tx (dir_tx),
      .oe_n   (oe_n),
      .ctl    (ctl)
   );

   xor_reduce #(.W(W), .STYLE(STYLE)) u_tx_par (
      .din (a_in),
      .odd (tx_odd)
   );

   xor_reduce #(.W(RXW), .STYLE(STYLE)) u_rx_par (
      .din ({par_in, b_in}),
      .odd (rx_odd)
   );

   parity_check u_chk (
      .chk_on  (ctl.chk_on),
      .odd_sel (odd_sel),
      .rx_odd  (rx_odd),
      .err_n   (err_n)
   );

   always_comb begin
      a_out   = b_in;
      b_out   = a_in;
      a_oe    = ctl.a_drv;
      b_oe    = ctl.b_drv;
      par_oe  = ctl.p_drv;
      par_out = tx_odd ^ odd_sel;
   end
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
   parameter int W = 8
) (
   input logic         dir_tx,
   input logic         oe_n,
   input logic         odd_sel,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_out,
   input logic         b_oe,
   input logic         par_in,
   input logic         par_out,
   input logic         par_oe,
   input logic         err_n
);
   always_comb begin
      // R1
      b_follows_a_chk: assert (!b_oe || (b_out == a_in && dir_tx && !a_oe));
      // R2
      a_follows_b_chk: assert (!a_oe || (a_out == b_in && !dir_tx && !b_oe));
      // R3
      released_chk: assert (!oe_n || (!a_oe && !b_oe));
      // R4
      even_gen_chk: assert (!(par_oe && !odd_sel) || ((^{a_in, par_out}) == 1'b0));
      // R5
      odd_gen_chk: assert (!(par_oe && odd_sel) || ((^{a_in, par_out}) == 1'b1));
      // R6
      even_flag_chk: assert (!(a_oe && !odd_sel) || (err_n == ~(^{b_in, par_in})));
      // R7
      odd_flag_chk: assert (!(a_oe && odd_sel) || (err_n == (^{b_in, par_in})));
      // R8
      par_drive_chk: assert (!par_oe || (dir_tx && !oe_n && b_oe));
      // R9
      quiet_flag_chk: assert (err_n || (!dir_tx && !oe_n));
   end
endmodule

bind parity_xcvr parity_xcvr_chk #(.W(W)) u_prop (
   .dir_tx  (dir_tx),
   .oe_n    (oe_n),
   .odd_sel (odd_sel),
   .a_in    (a_in),
   .a_out   (a_out),
   .a_oe    (a_oe),
   .b_in    (b_in),
   .b_out   (b_out),
   .b_oe    (b_oe),
   .par_in  (par_in),
   .par_out (par_out),
   .par_oe  (par_oe),
   .err_n   (err_n)
);

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic         dir_tx;
      logic         oe_n;
      logic         odd_sel;
      logic [W-1:0] a_in;
      logic [W-1:0] b_in;
      logic         par_in;
      logic         e_a_oe;
      logic         e_b_oe;
      logic         e_par_oe;
      logic         e_par;
      logic         e_err_n;
   } item_t;

   logic         clk = 1'b0;
   logic         dir_tx = 1'b0;
   logic         oe_n = 1'b1;
   logic         odd_sel = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         par_in = 1'b0;
   logic [W-1:0] a_out;
   logic [W-1:0] b_out;
   logic         a_oe;
   logic         b_oe;
   logic         par_out;
   logic         par_oe;
   logic         err_n;

   int    total = 0;
   int    bad   = 0;
   int    cycles = 0;
   bit    drv_done = 1'b0;
   item_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   parity_xcvr #(.W(W)) uut (
      .dir_tx  (dir_tx),
      .oe_n    (oe_n),
      .odd_sel (odd_sel),
      .a_in    (a_in),
      .a_out   (a_out),
      .a_oe    (a_oe),
      .b_in    (b_in),
      .b_out   (b_out),
      .b_oe    (b_oe),
      .par_in  (par_in),
      .par_out (par_out),
      .par_oe  (par_oe),
      .err_n   (err_n)
   );

   function automatic int ones(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver: applies one pattern at the falling edge and queues the prediction
   task automatic drive(input logic d, input logic oe, input logic osel,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
      item_t it;
      int    rx_cnt;
      @(negedge clk);
      dir_tx = d; oe_n = oe; odd_sel = osel; a_in = a; b_in = b; par_in = p;
      it.dir_tx = d; it.oe_n = oe; it.odd_sel = osel;
      it.a_in = a; it.b_in = b; it.par_in = p;
      it.e_a_oe   = !oe && !d;
      it.e_b_oe   = !oe && d;
      it.e_par_oe = !oe && d;
      it.e_par    = ((ones(a) % 2) == 1) ? !osel : osel;
      rx_cnt      = ones(b) + int'(p);
      if (oe || d) it.e_err_n = 1'b1;
      else if (!osel) it.e_err_n = ((rx_cnt % 2) == 1) ? 1'b0 : 1'b1;
      else it.e_err_n = ((rx_cnt % 2) == 0) ? 1'b0 : 1'b1;
      sb.push_back(it);
   endtask

   // monitor: compares at the rising edge, half a period after the drive
   always @(posedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         if (it.oe_n) begin
            chk(a_oe == 1'b0, "R3", "a_oe", a_oe, 0);
            chk(b_oe == 1'b0, "R3", "b_oe", b_oe, 0);
         end else if (it.dir_tx) begin
            chk(b_out == it.a_in, "R1", "b_out", b_out, it.a_in);
            chk(b_oe == 1'b1 && a_oe == 1'b0, "R1", "b_oe/a_oe",
                {b_oe, a_oe}, 2'b10);
         end else begin
            chk(a_out == it.b_in, "R2", "a_out", a_out, it.b_in);
            chk(a_oe == 1'b1 && b_oe == 1'b0, "R2", "a_oe/b_oe",
                {a_oe, b_oe}, 2'b10);
         end
         if (it.dir_tx) begin
            if (!it.odd_sel) chk(par_out == it.e_par, "R4", "par_out", par_out, it.e_par);
            else             chk(par_out == it.e_par, "R5", "par_out", par_out, it.e_par);
         end
         chk(par_oe == it.e_par_oe, "R8", "par_oe", par_oe, it.e_par_oe);
         if (it.oe_n || it.dir_tx)
            chk(err_n == 1'b1, "R9", "err_n", err_n, 1);
         else if (!it.odd_sel)
            chk(err_n == it.e_err_n, "R6", "err_n", err_n, it.e_err_n);
         else
            chk(err_n == it.e_err_n, "R7", "err_n", err_n, it.e_err_n);
      end
   end

   initial begin
      logic [W-1:0] pats [6];
      // idle state before any pattern: released, no flag (R3, R8, R9)
      #(CLK_PERIOD / 4);
      chk(a_oe == 1'b0 && b_oe == 1'b0, "R3", "idle oe", {a_oe, b_oe}, 0);
      chk(par_oe == 1'b0, "R8", "idle par_oe", par_oe, 0);
      chk(err_n == 1'b1, "R9", "idle err_n", err_n, 1);
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = 8'h01;
      pats[3] = 8'h80;
      pats[4] = 8'h5A;
      pats[5] = 8'h37;
      for (int m = 0; m < 8; m++) begin
         for (int i = 0; i < 6; i++) begin
            for (int p = 0; p < 2; p++) begin
               drive(m[2], m[1], m[0], pats[i], pats[5 - i], p[0]);
            end
         end
         for (int r = 0; r < 40; r++) begin
            drive(m[2], m[1], m[0], W'($urandom), W'($urandom), 1'($urandom));
         end
      end
      @(negedge clk);
      @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin
      while (!drv_done && cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!drv_done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule